// File: doc/BRIEF.md
# Load-Use Hazard Detector with Store-Data Forwarding

This block decides, every cycle, whether a five-stage pipeline must hold or flush its front stages. It looks at the opcodes and register numbers in decode and execute, at the opcode in memory, and at the register that the memory stage is loading. From these it produces stall and bubble controls for the fetch, decode and execute pipeline registers. It also produces the data operand that the store in execute passes on to memory.

The block differs from a plain load-use interlock in one case. A load or pop may be followed directly by a store or push. If that store or push uses the loaded register only as the value to write, the pipeline does not stall. The store moves on into execute, and in the next cycle the word that the load has just read in the memory stage replaces the store's stale data operand. A dependence through source B, or through source A of any other opcode, still costs one stall cycle.

The logic is purely combinational and has no states. The house layout is kept, but there is no state register. The design has three parts: a load-use detector, a store-data forwarding selector, and a control arbiter that merges the load-use, return and misprediction conditions.

Top module: `pipe_hazard_fwd`

## Requirements
- R1: If execute holds a load (opcode 4'h5) or a pop (4'hB), and its load destination equals decode source B, then `lu_stall` is 1.
- R2: If that load destination equals decode source A, `lu_stall` is 1 unless the decode opcode is a store (4'h4) or a push (4'hA). In that case, and when there is no match on source B, `lu_stall` is 0.
- R3: The register number 4'hF means "no register". As a load destination in execute it never raises `lu_stall`. As the memory-stage load destination it never causes forwarding.
- R4: If execute holds a store or push, and `mem_dst_m` equals `exe_src_a`, then `fwd_data` equals `mem_rd_data`. In every other case `fwd_data` equals `exe_store_data`.
- R5: While `lu_stall` is 1, `f_stall` and `d_stall` are 1 and `e_bubble` is 1.
- R6: A return (opcode 4'h9) in decode, execute or memory sets `f_stall`. It also sets `d_bubble`, but only when `lu_stall` is 0.
- R7: When `mispredict` is 1, both `d_bubble` and `e_bubble` are 1.
- R8: When no load-use hazard, no return and no misprediction is present, all stall and bubble outputs are 0. For example, all three opcodes may be nop (4'h1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_op | input | 4 | Opcode of the instruction in decode |
| dec_src_a | input | 4 | Decode source register A |
| dec_src_b | input | 4 | Decode source register B |
| exe_op | input | 4 | Opcode of the instruction in execute |
| exe_dst_m | input | 4 | Load destination of the instruction in execute |
| exe_src_a | input | 4 | Source register A of the instruction in execute |
| exe_store_data | input | 64 | Data operand carried by the instruction in execute |
| mem_op | input | 4 | Opcode of the instruction in memory |
| mem_dst_m | input | 4 | Load destination of the instruction in memory |
| mem_rd_data | input | 64 | Word read from memory this cycle |
| mispredict | input | 1 | The conditional branch in execute was mispredicted |
| lu_stall | output | 1 | Load-use hazard after the store-forwarding relief |
| f_stall | output | 1 | Hold the fetch register |
| d_stall | output | 1 | Hold the decode register |
| d_bubble | output | 1 | Load a bubble into the decode register |
| e_bubble | output | 1 | Load a bubble into the execute register |
| fwd_data | output | 64 | Store data operand after forwarding |

## Verification
The checks take for granted that the inputs describe a consistent pipeline. `mispredict` is only raised while execute holds a jump (4'h7). Because of this, a load in execute and a mispredicted branch never occur together, and decode is never told to stall and bubble at once. Load destinations other than 4'hF appear only with a load or pop opcode. The random stimulus draws opcodes and register numbers from small pools so that matches happen often. It derives `exe_dst_m` from `exe_op`, and it raises `mispredict` only when it has picked a jump for execute.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int OP_W  = 4;
    localparam int REG_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 4'h1,
        OP_STORE = 4'h4,
        OP_LOAD  = 4'h5,
        OP_JUMP  = 4'h7,
        OP_RET   = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB
    } op_e;

    localparam logic [REG_W-1:0] REG_NONE = 4'hF;

    function automatic logic is_loader(input logic [OP_W-1:0] op);
        return (op == OP_LOAD) || (op == OP_POP);
    endfunction

    function automatic logic is_storer(input logic [OP_W-1:0] op);
        return (op == OP_STORE) || (op == OP_PUSH);
    endfunction
endpackage

// File: rtl/hz_loaduse.sv
module hz_loaduse
    import hz_pkg::*;
(
    input  logic [OP_W-1:0]  dec_op,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic [OP_W-1:0]  exe_op,
    input  logic [REG_W-1:0] exe_dst_m,
    output logic             hazard
);
    logic dst_real, hit_a, hit_b, a_is_late;

    always_comb begin
        dst_real  = is_loader(exe_op) && (exe_dst_m != REG_NONE);
        hit_a     = dst_real && (exe_dst_m == dec_src_a);
        hit_b     = dst_real && (exe_dst_m == dec_src_b);
        // a store or push reads source A only in the memory stage
        a_is_late = is_storer(dec_op);
        hazard    = hit_b || (hit_a && !a_is_late);
    end
endmodule

// File: rtl/hz_fwd.sv
module hz_fwd
    import hz_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [OP_W-1:0]   exe_op,
    input  logic [REG_W-1:0]  exe_src_a,
    input  logic [DATA_W-1:0] exe_store_data,
    input  logic [REG_W-1:0]  mem_dst_m,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic [DATA_W-1:0] fwd_data
);
    logic take_mem;

    always_comb begin
        take_mem = is_storer(exe_op) && (mem_dst_m != REG_NONE)
                   && (mem_dst_m == exe_src_a);
        fwd_data = take_mem ? mem_rd_data : exe_store_data;
    end
endmodule

// File: rtl/hz_arbiter.sv
module hz_arbiter
    import hz_pkg::*;
(
    input  logic [OP_W-1:0] dec_op,
    input  logic [OP_W-1:0] exe_op,
    input  logic [OP_W-1:0] mem_op,
    input  logic            lu,
    input  logic            mispredict,
    output logic            f_stall,
    output logic            d_stall,
    output logic            d_bubble,
    output logic            e_bubble
);
    logic ret_live;

    always_comb begin
        ret_live = (dec_op == OP_RET) || (exe_op == OP_RET) || (mem_op == OP_RET);
        f_stall  = lu || ret_live;
        d_stall  = lu;
        d_bubble = mispredict || (ret_live && !lu);
        e_bubble = mispredict || lu;
    end
endmodule

// File: rtl/pipe_hazard_fwd.sv
module pipe_hazard_fwd
    import hz_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [3:0]        dec_op,
    input  logic [3:0]        dec_src_a,
    input  logic [3:0]        dec_src_b,
    input  logic [3:0]        exe_op,
    input  logic [3:0]        exe_dst_m,
    input  logic [3:0]        exe_src_a,
    input  logic [DATA_W-1:0] exe_store_data,
    input  logic [3:0]        mem_op,
    input  logic [3:0]        mem_dst_m,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              mispredict,
    output logic              lu_stall,
    output logic              f_stall,
    output logic              d_stall,
    output logic              d_bubble,
    output logic              e_bubble,
    output logic [DATA_W-1:0] fwd_data
);
    logic lu_int;

    hz_loaduse u_lu (
        .dec_op    (dec_op),
        .dec_src_a (dec_src_a),
        .dec_src_b (dec_src_b),
        .exe_op    (exe_op),
        .exe_dst_m (exe_dst_m),
        .hazard    (lu_int)
    );

    hz_fwd #(.DATA_W(DATA_W)) u_fwd (
        .exe_op         (exe_op),
        .exe_src_a      (exe_src_a),
        .exe_store_data (exe_store_data),
        .mem_dst_m      (mem_dst_m),
        .mem_rd_data    (mem_rd_data),
        .fwd_data       (fwd_data)
    );

    hz_arbiter u_arb (
        .dec_op     (dec_op),
        .exe_op     (exe_op),
        .mem_op     (mem_op),
        .lu         (lu_int),
        .mispredict (mispredict),
        .f_stall    (f_stall),
        .d_stall    (d_stall),
        .d_bubble   (d_bubble),
        .e_bubble   (e_bubble)
    );

    assign lu_stall = lu_int;
endmodule

// File: rtl/pipe_hazard_fwd_chk.sv
module pipe_hazard_fwd_chk
    import hz_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic [3:0]        dec_op,
    input logic [3:0]        dec_src_a,
    input logic [3:0]        dec_src_b,
    input logic [3:0]        exe_op,
    input logic [3:0]        exe_dst_m,
    input logic [3:0]        exe_src_a,
    input logic [DATA_W-1:0] exe_store_data,
    input logic [3:0]        mem_op,
    input logic [3:0]        mem_dst_m,
    input logic [DATA_W-1:0] mem_rd_data,
    input logic              mispredict,
    input logic              lu_stall,
    input logic              f_stall,
    input logic              d_stall,
    input logic              d_bubble,
    input logic              e_bubble,
    input logic [DATA_W-1:0] fwd_data
);
    always_comb begin
        // R5: a load-use stall holds fetch and decode and empties execute
        p_stall_set_r5: assert (!lu_stall || (f_stall && d_stall && e_bubble));
        // R2: a loaded value used only as store data causes no stall
        p_store_relief_r2: assert (!(is_storer(dec_op) && is_loader(exe_op)
                                     && exe_dst_m == dec_src_a && exe_dst_m != dec_src_b)
                                   || !lu_stall);
        // R3: the no-register number never interlocks or forwards
        p_none_quiet_r3: assert (exe_dst_m != REG_NONE || !lu_stall);
        p_none_nofwd_r3: assert (mem_dst_m != REG_NONE || fwd_data == exe_store_data);
        // R4: only a store or push in execute can take memory data
        p_fwd_only_store_r4: assert (is_storer(exe_op) || fwd_data == exe_store_data);
        // R7: a misprediction flushes decode and execute
        p_flush_r7: assert (!mispredict || (d_bubble && e_bubble));
        // R6: decode is never told to hold and to flush at once
        p_dec_excl_r6: assert (mispredict || !(d_stall && d_bubble));
    end
endmodule

bind pipe_hazard_fwd pipe_hazard_fwd_chk #(.DATA_W(DATA_W)) u_chk (
    .dec_op(dec_op), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .exe_op(exe_op), .exe_dst_m(exe_dst_m), .exe_src_a(exe_src_a),
    .exe_store_data(exe_store_data), .mem_op(mem_op), .mem_dst_m(mem_dst_m),
    .mem_rd_data(mem_rd_data), .mispredict(mispredict), .lu_stall(lu_stall),
    .f_stall(f_stall), .d_stall(d_stall), .d_bubble(d_bubble),
    .e_bubble(e_bubble), .fwd_data(fwd_data)
);

// File: tb/pipe_hazard_fwd_test.sv
`timescale 1ns/1ps
module pipe_hazard_fwd_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [3:0]  dec_op, dec_src_a, dec_src_b, exe_op, exe_dst_m, exe_src_a, mem_op, mem_dst_m;
    logic [63:0] exe_store_data, mem_rd_data, fwd_data;
    logic        mispredict, lu_stall, f_stall, d_stall, d_bubble, e_bubble;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    pipe_hazard_fwd uut (.*);

    function automatic bit ld(input logic [3:0] op);
        return op == 4'h5 || op == 4'hB;
    endfunction
    function automatic bit st(input logic [3:0] op);
        return op == 4'h4 || op == 4'hA;
    endfunction
    function automatic bit exp_lu();
        bit real_d = ld(exe_op) && exe_dst_m != 4'hF;
        return real_d && (exe_dst_m == dec_src_b ||
                          (exe_dst_m == dec_src_a && !st(dec_op)));
    endfunction
    function automatic bit exp_ret();
        return dec_op == 4'h9 || exe_op == 4'h9 || mem_op == 4'h9;
    endfunction
    function automatic logic [63:0] exp_fwd();
        if (st(exe_op) && mem_dst_m != 4'hF && mem_dst_m == exe_src_a) return mem_rd_data;
        return exe_store_data;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        bit l = exp_lu();
        bit r = exp_ret();
        chk({tag, " R1/R2/R3 lu_stall"}, lu_stall, l);
        chk({tag, " R5/R6 f_stall"}, f_stall, l || r);
        chk({tag, " R5 d_stall"}, d_stall, l);
        chk({tag, " R6/R7 d_bubble"}, d_bubble, mispredict || (r && !l));
        chk({tag, " R5/R7 e_bubble"}, e_bubble, mispredict || l);
        chk({tag, " R4 fwd_data"}, fwd_data, exp_fwd());
    endtask

    task automatic idle();
        dec_op = 4'h1; dec_src_a = 4'hF; dec_src_b = 4'hF;
        exe_op = 4'h1; exe_dst_m = 4'hF; exe_src_a = 4'hF;
        mem_op = 4'h1; mem_dst_m = 4'hF; mispredict = 1'b0;
        exe_store_data = 64'h1111_2222_3333_4444;
        mem_rd_data    = 64'hAAAA_BBBB_CCCC_DDDD;
    endtask

    task automatic apply(input string tag);
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    logic [3:0] ops[8] = '{4'h1, 4'h4, 4'h5, 4'h7, 4'h9, 4'hA, 4'hB, 4'h6};

    initial begin
        void'($urandom(32'h5EED_0042));
        idle();
        // R8: quiet pipeline, nothing asserted
        apply("R8 idle");
        chk("R8 all quiet", {lu_stall, f_stall, d_stall, d_bubble, e_bubble}, 5'b0);

        // R1: load dest matches decode source B
        idle(); exe_op = 4'h5; exe_dst_m = 4'h3; dec_op = 4'h6; dec_src_b = 4'h3;
        apply("R1 srcB");
        chk("R1 stall", lu_stall, 1'b1);

        // R2: store using loaded reg as data: no stall
        idle(); exe_op = 4'hB; exe_dst_m = 4'h2; dec_op = 4'h4; dec_src_a = 4'h2; dec_src_b = 4'h5;
        apply("R2 store relief");
        chk("R2 no stall", lu_stall, 1'b0);

        // R2: same match on non-store opcode stalls
        dec_op = 4'h6;
        apply("R2 op stalls");
        chk("R2 stall", lu_stall, 1'b1);

        // R2: push whose base also matches (src B) still stalls
        dec_op = 4'hA; dec_src_b = 4'h2;
        apply("R2 push srcB");
        chk("R2 push stall", lu_stall, 1'b1);

        // R3: none register in both dest and source
        idle(); exe_op = 4'h5; exe_dst_m = 4'hF; dec_op = 4'h6;
        apply("R3 none");
        chk("R3 no stall", lu_stall, 1'b0);
        idle(); exe_op = 4'h4; exe_src_a = 4'hF; mem_dst_m = 4'hF;
        apply("R3 none fwd");
        chk("R3 no fwd", fwd_data, 64'h1111_2222_3333_4444);

        // R4: forward from memory into store data
        idle(); exe_op = 4'hA; exe_src_a = 4'h7; mem_dst_m = 4'h7;
        apply("R4 fwd");
        chk("R4 fwd data", fwd_data, 64'hAAAA_BBBB_CCCC_DDDD);
        exe_op = 4'h6;
        apply("R4 non-store");
        chk("R4 no fwd", fwd_data, 64'h1111_2222_3333_4444);

        // R6: return plus load-use: decode not bubbled
        idle(); mem_op = 4'h9;
        apply("R6 ret");
        chk("R6 bubble", d_bubble, 1'b1);
        exe_op = 4'h5; exe_dst_m = 4'h1; dec_op = 4'h9; dec_src_b = 4'h1;
        apply("R6 ret+lu");
        chk("R6 no bubble", d_bubble, 1'b0);

        // R7: mispredict
        idle(); exe_op = 4'h7; mispredict = 1'b1; dec_op = 4'h9;
        apply("R7 mispredict");
        chk("R7 flush", {d_bubble, e_bubble}, 2'b11);

        for (int i = 0; i < 600; i++) begin
            idle();
            dec_op    = ops[$urandom_range(7)];
            exe_op    = ops[$urandom_range(7)];
            mem_op    = ops[$urandom_range(7)];
            dec_src_a = ($urandom_range(5) == 0) ? 4'hF : 4'($urandom_range(3));
            dec_src_b = ($urandom_range(5) == 0) ? 4'hF : 4'($urandom_range(3));
            exe_src_a = ($urandom_range(5) == 0) ? 4'hF : 4'($urandom_range(3));
            exe_dst_m = ld(exe_op) ? (($urandom_range(6) == 0) ? 4'hF : 4'($urandom_range(3))) : 4'hF;
            mem_dst_m = ld(mem_op) ? (($urandom_range(6) == 0) ? 4'hF : 4'($urandom_range(3))) : 4'hF;
            mispredict = (exe_op == 4'h7) && $urandom_range(1) == 1;
            exe_store_data = {$urandom, $urandom};
            mem_rd_data    = {$urandom, $urandom};
            apply("random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule